// File: doc/BRIEF.md
# PLL Loss-of-Lock Recovery Supervisor

This block keeps watch over the lock indication of a clock-synthesis PLL. It runs on a free-running monitor clock of 50 MHz or lower that does not come from the PLL it supervises. The raw lock signal is brought into that clock domain through a two-flop synchronizer, and only the synchronized copy is used.

A short loss of lock is tolerated. The block waits out a programmable self-recovery window and does nothing if lock comes back inside it. If lock is still missing when the window expires, the block escalates. It raises a safe-state request to the rest of the chip and drives a reset/powerdown pulse of fixed width into the PLL. It then waits for lock to return. If lock does not return within an acquisition timeout, it pulses the PLL again.

Once lock is back, it must hold without a break for a qualification count before the block drops the safe-state request and raises clock-good. Every escalation increments a saturating event counter.

Top module: `pll_lock_supervisor`

## Requirements
- R1: While `mon_rst_n` is low at a clock edge, the block resets to the acquisition wait: `pll_rst_o`=0, `safe_req_o`=1, `clk_good_o`=0, `esc_cnt_o`=0.
- R2: `lock_raw_i` passes through two monitor-clock flops before any decision. If lock drops during normal operation and is first sampled low at edge k, `clk_good_o` stays high through edge k+1 and goes low after edge k+2.
- R3: If lock is sampled low for at most GRACE_CYC consecutive edges during normal operation, the following all hold: `safe_req_o` and `pll_rst_o` stay low, `clk_good_o` comes back high, and `esc_cnt_o` is unchanged.
- R4: If lock is sampled low for GRACE_CYC+1 or more consecutive edges starting at edge k, the block escalates. `pll_rst_o` and `safe_req_o` go high after edge k+GRACE_CYC+2, and `esc_cnt_o` increases by one at that same edge.
- R5: Each PLL reset pulse keeps `pll_rst_o` high for exactly PULSE_CYC monitor cycles. It then releases `pll_rst_o`, and `safe_req_o` stays high.
- R6: If synchronized lock is not seen within ACQ_CYC cycles after a pulse ends, `pll_rst_o` rises again after exactly ACQ_CYC low cycles, and `esc_cnt_o` increases by one.
- R7: Clock-good returns only after synchronized lock has held for QUAL_CYC consecutive cycles. If lock is raised and first sampled high at edge k during acquisition, `clk_good_o` goes high after edge k+QUAL_CYC+2. A lock drop during qualification restarts the count and causes no new reset pulse.
- R8: `clk_good_o` is high only in normal operation. `safe_req_o` is high from the reset pulse through qualification and low in normal operation and in the self-recovery window. `pll_rst_o` high implies `safe_req_o` high.
- R9: `esc_cnt_o` is EVT_W bits wide. It saturates at 2^EVT_W-1 and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mon_clk | input | 1 | Free-running monitor clock, independent of the PLL |
| mon_rst_n | input | 1 | Synchronous active-low reset |
| lock_raw_i | input | 1 | Raw PLL lock indication, asynchronous to mon_clk |
| pll_rst_o | output | 1 | Reset/powerdown drive to the PLL |
| safe_req_o | output | 1 | Request for the rest of the design to hold a safe state |
| clk_good_o | output | 1 | High while the PLL output is considered usable |
| esc_cnt_o | output | EVT_W | Saturating count of escalations to a PLL reset |

## Verification
Lock drops of exactly GRACE_CYC and GRACE_CYC+1 sampled edges are applied. These separate tolerance from escalation at the exact boundary, and a sustained drop pins down the synchronizer latency and the escalation cycle. Holding lock low after a pulse separates the pulse width from the acquisition timeout, because the high and low runs of `pll_rst_o` are measured separately. During qualification, a single-cycle lock glitch shows that the count restarts instead of continuing. A long outage drives repeated pulses to show that the event counter stops at its maximum.

// File: rtl/pls_pkg.sv
// Shared types for the PLL lock supervisor.
// Assumes nothing beyond a single monitor clock domain.
package pls_pkg;

    typedef enum logic [2:0] {
        ST_RUN        = 3'd0,
        ST_GRACE      = 3'd1,
        ST_SAFE_RESET = 3'd2,
        ST_ACQUIRE    = 3'd3,
        ST_QUALIFY    = 3'd4
    } sup_state_t;

endpackage

// File: rtl/pls_sync.sv
// Multi-flop synchronizer bringing the raw lock level into the monitor domain.
// Assumes the input is a level that changes slowly relative to mon_clk.
module pls_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_i};
    end

    assign q_o = chain[STAGES-1];

endmodule

// File: rtl/pls_fsm.sv
// Recovery state machine with one shared interval timer.
// Assumes lock_s is already synchronized; all interval parameters are >= 2.
module pls_fsm
    import pls_pkg::*;
#(
    parameter int unsigned GRACE_CYC = 8,
    parameter int unsigned PULSE_CYC = 4,
    parameter int unsigned ACQ_CYC   = 32,
    parameter int unsigned QUAL_CYC  = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lock_s,
    output sup_state_t state_o,
    output logic       esc_o
);

    localparam int unsigned MAX_GP  = (GRACE_CYC > PULSE_CYC) ? GRACE_CYC : PULSE_CYC;
    localparam int unsigned MAX_AQ  = (ACQ_CYC > QUAL_CYC) ? ACQ_CYC : QUAL_CYC;
    localparam int unsigned MAX_ALL = (MAX_GP > MAX_AQ) ? MAX_GP : MAX_AQ;
    localparam int unsigned TW      = $clog2(MAX_ALL + 1);

    localparam logic [TW-1:0] G_LAST = TW'(GRACE_CYC - 1);
    localparam logic [TW-1:0] P_LAST = TW'(PULSE_CYC - 1);
    localparam logic [TW-1:0] A_LAST = TW'(ACQ_CYC - 1);
    localparam logic [TW-1:0] Q_LAST = TW'(QUAL_CYC - 1);

    sup_state_t    state, nstate;
    logic [TW-1:0] cnt, ncnt;

    // Next-state, timer and escalation-strobe decode.
    always_comb begin
        nstate = state;
        ncnt   = cnt + 1'b1;
        esc_o  = 1'b0;
        unique case (state)
            ST_RUN: begin
                ncnt = '0;
                if (!lock_s) nstate = ST_GRACE;
            end
            ST_GRACE: begin
                if (lock_s) begin
                    nstate = ST_RUN;
                    ncnt   = '0;
                end else if (cnt == G_LAST) begin
                    nstate = ST_SAFE_RESET;
                    ncnt   = '0;
                    esc_o  = 1'b1;
                end
            end
            ST_SAFE_RESET: begin
                if (cnt == P_LAST) begin
                    nstate = ST_ACQUIRE;
                    ncnt   = '0;
                end
            end
            ST_ACQUIRE: begin
                if (lock_s) begin
                    nstate = ST_QUALIFY;
                    ncnt   = '0;
                end else if (cnt == A_LAST) begin
                    nstate = ST_SAFE_RESET;
                    ncnt   = '0;
                    esc_o  = 1'b1;
                end
            end
            ST_QUALIFY: begin
                if (!lock_s) begin
                    nstate = ST_ACQUIRE;
                    ncnt   = '0;
                end else if (cnt == Q_LAST) begin
                    nstate = ST_RUN;
                    ncnt   = '0;
                end
            end
            default: begin
                nstate = ST_ACQUIRE;
                ncnt   = '0;
            end
        endcase
    end

    // State and timer registers; power-on waits for first lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_ACQUIRE;
            cnt   <= '0;
        end else begin
            state <= nstate;
            cnt   <= ncnt;
        end
    end

    assign state_o = state;

    // R3: a synchronized drop in RUN opens the self-recovery window.
    assert_grace_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !lock_s) |=> state == ST_GRACE);

    // R3: lock returning inside the window resumes RUN.
    assert_grace_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GRACE && lock_s) |=> state == ST_RUN);

    // R5: the pulse holds until its last cycle, then moves to acquisition.
    assert_pulse_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SAFE_RESET && cnt != P_LAST) |=> state == ST_SAFE_RESET);
    assert_pulse_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SAFE_RESET && cnt == P_LAST) |=> state == ST_ACQUIRE);

    // R7: a drop during qualification restarts acquisition.
    assert_qual_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_QUALIFY && !lock_s) |=> state == ST_ACQUIRE);

endmodule

// File: rtl/pls_evt_cnt.sv
// Saturating escalation counter.
// Assumes inc_i is a single-cycle strobe per escalation.
module pls_evt_cnt #(
    parameter int unsigned W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);

    localparam logic [W-1:0] SAT = '1;

    // Count escalations, holding at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt_o <= '0;
        else if (inc_i && cnt_o != SAT) cnt_o <= cnt_o + 1'b1;
    end

    // R9: once saturated the count never moves.
    assert_evt_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == SAT) |=> cnt_o == SAT);

    // R9: below saturation each strobe adds exactly one.
    assert_evt_inc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && cnt_o != SAT) |=> cnt_o == $past(cnt_o) + 1'b1);

endmodule

// File: rtl/pll_lock_supervisor.sv
// Top of the PLL loss-of-lock supervisor: synchronizer, recovery FSM,
// escalation counter and output decode. Assumes mon_clk is free-running,
// 50 MHz or slower, and not derived from the supervised PLL.
module pll_lock_supervisor
    import pls_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned GRACE_CYC   = 8,
    parameter int unsigned PULSE_CYC   = 4,
    parameter int unsigned ACQ_CYC     = 32,
    parameter int unsigned QUAL_CYC    = 1024,
    parameter int unsigned EVT_W       = 3
) (
    input  logic             mon_clk,
    input  logic             mon_rst_n,
    input  logic             lock_raw_i,
    output logic             pll_rst_o,
    output logic             safe_req_o,
    output logic             clk_good_o,
    output logic [EVT_W-1:0] esc_cnt_o
);

    logic       lock_s;
    logic       esc;
    sup_state_t state;

    pls_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (mon_clk),
        .rst_n (mon_rst_n),
        .d_i   (lock_raw_i),
        .q_o   (lock_s)
    );

    pls_fsm #(
        .GRACE_CYC (GRACE_CYC),
        .PULSE_CYC (PULSE_CYC),
        .ACQ_CYC   (ACQ_CYC),
        .QUAL_CYC  (QUAL_CYC)
    ) u_fsm (
        .clk     (mon_clk),
        .rst_n   (mon_rst_n),
        .lock_s  (lock_s),
        .state_o (state),
        .esc_o   (esc)
    );

    pls_evt_cnt #(.W(EVT_W)) u_evt (
        .clk   (mon_clk),
        .rst_n (mon_rst_n),
        .inc_i (esc),
        .cnt_o (esc_cnt_o)
    );

    // Decode the outputs from the registered state.
    always_comb begin
        pll_rst_o  = (state == ST_SAFE_RESET);
        clk_good_o = (state == ST_RUN);
        safe_req_o = (state == ST_SAFE_RESET) || (state == ST_ACQUIRE) ||
                     (state == ST_QUALIFY);
    end

    // R8: the PLL is only reset while the design is held safe.
    assert_rst_in_safe_R8: assert property (@(posedge mon_clk) disable iff (!mon_rst_n)
        pll_rst_o |-> safe_req_o);

    // R8: clock-good and safe request never overlap.
    assert_good_excl_R8: assert property (@(posedge mon_clk) disable iff (!mon_rst_n)
        clk_good_o |-> !safe_req_o);

    // R7: clock-good only rises after synchronized lock was seen.
    assert_good_locked_R7: assert property (@(posedge mon_clk) disable iff (!mon_rst_n)
        $rose(clk_good_o) |-> $past(lock_s));

    // R4: every escalation strobe leads into a reset pulse.
    assert_esc_pulse_R4: assert property (@(posedge mon_clk) disable iff (!mon_rst_n)
        esc |=> pll_rst_o);

endmodule

// File: tb/sim_pll_lock_supervisor.sv
// Directed bench for the PLL lock supervisor.
module sim_pll_lock_supervisor;

    localparam int CLK_PERIOD = 20;
    localparam int GRACE  = 8;
    localparam int PULSE  = 4;
    localparam int ACQ    = 32;
    localparam int QUAL   = 1024;
    localparam int EVT_W  = 3;
    localparam int EVT_MAX = (1 << EVT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             lock_raw = 1'b0;
    logic             pll_rst;
    logic             safe_req;
    logic             clk_good;
    logic [EVT_W-1:0] esc_cnt;

    int n_checks = 0;
    int n_fail   = 0;

    pll_lock_supervisor #(
        .GRACE_CYC (GRACE),
        .PULSE_CYC (PULSE),
        .ACQ_CYC   (ACQ),
        .QUAL_CYC  (QUAL),
        .EVT_W     (EVT_W)
    ) u0 (
        .mon_clk    (clk),
        .mon_rst_n  (rst_n),
        .lock_raw_i (lock_raw),
        .pll_rst_o  (pll_rst),
        .safe_req_o (safe_req),
        .clk_good_o (clk_good),
        .esc_cnt_o  (esc_cnt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Advance one edge and settle at the falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Count edges until pll_rst equals want (bounded).
    task automatic wait_rst(input bit want, input int limit, output int n);
        n = 0;
        while (pll_rst != want && n < limit) begin
            step();
            n++;
        end
    endtask

    // Count edges until clk_good goes high (bounded).
    task automatic wait_good(input int limit, output int n);
        n = 0;
        while (!clk_good && n < limit) begin
            step();
            n++;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        lock_raw = 1'b0;
        repeat (3) step();
        check(pll_rst == 1'b0, "R1 pll_rst", pll_rst, 0);
        check(safe_req == 1'b1, "R1 safe_req", safe_req, 1);
        check(clk_good == 1'b0, "R1 clk_good", clk_good, 0);
        check(esc_cnt == 0, "R1 esc_cnt", esc_cnt, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_startup();
        int n;
        lock_raw = 1'b1;
        wait_good(5000, n);
        check(n == QUAL + 3, "R7 startup qualification edges", n, QUAL + 3);
        check(safe_req == 1'b0, "R8 safe_req low in run", safe_req, 0);
        check(esc_cnt == 0, "R7 no escalation at startup", esc_cnt, 0);
    endtask

    task automatic t_short_drop();
        bit bad = 1'b0;
        lock_raw = 1'b0;
        repeat (GRACE) begin
            step();
            if (safe_req || pll_rst) bad = 1'b1;
        end
        lock_raw = 1'b1;
        repeat (4) begin
            step();
            if (safe_req || pll_rst) bad = 1'b1;
        end
        check(!bad, "R3 no safe/reset during short drop", bad, 0);
        check(clk_good == 1'b1, "R3 clk_good restored", clk_good, 1);
        check(esc_cnt == 0, "R3 counter unchanged", esc_cnt, 0);
    endtask

    task automatic t_escalate_and_acquire();
        int n;
        int w;
        lock_raw = 1'b0;
        step();
        step();
        check(clk_good == 1'b1, "R2 clk_good still high after k+1", clk_good, 1);
        step();
        check(clk_good == 1'b0, "R2 clk_good low after k+2", clk_good, 0);
        check(safe_req == 1'b0, "R8 safe_req low in grace", safe_req, 0);
        wait_rst(1'b1, 100, n);
        check(n + 3 == GRACE + 3, "R4 escalation edge", n + 3, GRACE + 3);
        check(safe_req == 1'b1, "R4 safe_req on escalation", safe_req, 1);
        check(esc_cnt == 1, "R4 counter after escalation", esc_cnt, 1);
        wait_rst(1'b0, 100, w);
        check(w == PULSE, "R5 pulse width", w, PULSE);
        check(safe_req == 1'b1, "R5 safe_req after pulse", safe_req, 1);
        wait_rst(1'b1, 200, n);
        check(n == ACQ, "R6 acquisition timeout", n, ACQ);
        check(esc_cnt == 2, "R6 counter after retry", esc_cnt, 2);
        wait_rst(1'b0, 100, w);
        check(w == PULSE, "R5 second pulse width", w, PULSE);
    endtask

    task automatic t_qualify_glitch();
        int n;
        bit bad = 1'b0;
        lock_raw = 1'b1;
        repeat (10) begin
            step();
            if (pll_rst || clk_good) bad = 1'b1;
        end
        lock_raw = 1'b0;
        step();
        lock_raw = 1'b1;
        repeat (4) begin
            step();
            if (pll_rst || clk_good) bad = 1'b1;
        end
        wait_good(5000, n);
        check(n + 4 == QUAL + 3, "R7 count restarted after glitch", n + 4, QUAL + 3);
        check(!bad, "R7 no pulse or clock-good during glitch", bad, 0);
        check(esc_cnt == 2, "R7 glitch not counted", esc_cnt, 2);
    endtask

    task automatic t_boundary_escalate();
        int n;
        lock_raw = 1'b0;
        repeat (GRACE + 1) step();
        lock_raw = 1'b1;
        wait_rst(1'b1, 20, n);
        check(pll_rst == 1'b1, "R4 escalation at GRACE+1 drop", pll_rst, 1);
        check(esc_cnt == 3, "R4 counter at boundary", esc_cnt, 3);
        wait_rst(1'b0, 100, n);
        wait_good(5000, n);
        check(clk_good == 1'b1, "R7 recovered after boundary case", clk_good, 1);
    endtask

    task automatic t_saturate();
        int n;
        bit wrapped = 1'b0;
        int prev;
        lock_raw = 1'b0;
        prev = esc_cnt;
        repeat (6) begin
            wait_rst(1'b1, 200, n);
            if (esc_cnt < prev) wrapped = 1'b1;
            prev = esc_cnt;
            wait_rst(1'b0, 100, n);
        end
        check(esc_cnt == EVT_MAX, "R9 counter saturated", esc_cnt, EVT_MAX);
        check(!wrapped, "R9 counter never wrapped", wrapped, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog all-R actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_startup();
        t_short_drop();
        t_escalate_and_acquire();
        t_qualify_glitch();
        t_boundary_escalate();
        t_saturate();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule